// File: doc/BRIEF.md
# Register-Port to Scan-Bus Bridge

This block sits between a narrow 32-bit slave register port and a 64-bit internal scan-communication bus. Software uses a few word addresses to stage a 64-bit value in two 32-bit halves. It then writes a command word whose top bit picks write or read and whose remaining 31 bits name the target register. That command write launches exactly one transaction on the internal bus. The transaction uses a request/acknowledge handshake with an error flag.

A read result lands in the same two 32-bit holding words, so software fetches the upper half and the lower half separately. A clear command returns the bridge to idle, which software issues before each access. A separate command pulses a reset line toward the internal bus for a fixed number of cycles. While a transaction is outstanding, further commands are refused and flagged in a sticky error bit. An error returned with the acknowledge is also kept sticky.

Top module: `scan_bridge`

## Requirements
- R1: After rst_n is released, busy, sb_req, bus_err, drop_err and sb_rst are 0, and both holding words read back as zero.
- R2: With the bridge idle, a write to word 0x0 loads the upper holding word and a write to word 0x1 loads the lower one. reg_rdata returns them at those addresses and returns zero at every other word address.
- R3: A write to word 0x2 while idle raises sb_req and busy on the next cycle. sb_we equals command bit 31 (1 = write), sb_addr equals command bits 30:0, and sb_wdata equals {upper word, lower word}.
- R4: When a read (bit 31 = 0) is acknowledged without error, the upper word takes sb_rdata[63:32] and the lower word takes sb_rdata[31:0] on the cycle after the acknowledge edge.
- R5: sb_req stays high, with sb_we, sb_addr and sb_wdata unchanged, until sb_ack is sampled high. busy and sb_req drop on the cycle after that edge.
- R6: While busy, a command write is dropped without changing the outstanding request and sets the sticky drop_err. Writes to words 0x0 and 0x1 have no effect while busy.
- R7: An acknowledge with sb_err high sets the sticky bus_err. A write acknowledge leaves both holding words unchanged whatever sb_rdata carries.
- R8: A read acknowledged with sb_err high loads all ones into both holding words.
- R9: A write to word 0x6 with bit 31 set clears busy, sb_req, bus_err, drop_err and both holding words on the next cycle. An acknowledge arriving after that clear has no effect. With bit 31 clear, the write does nothing.
- R10: A write to word 0x7 with bit 31 set drives sb_rst high for exactly BUS_RST_CYCLES cycles (default 4), starting on the next cycle. The word 0x6 clear never drives sb_rst, and a word 0x7 write with bit 31 clear does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register-port write strobe |
| reg_addr | input | 3 | Register-port word address (write and read) |
| reg_wdata | input | REG_W | Register-port write data |
| reg_rdata | output | REG_W | Register-port read data for reg_addr |
| busy | output | 1 | Transaction outstanding |
| bus_err | output | 1 | Sticky: acknowledge carried an error |
| drop_err | output | 1 | Sticky: command written while busy |
| sb_req | output | 1 | Internal bus request |
| sb_we | output | 1 | Internal bus write (1) or read (0) |
| sb_addr | output | REG_W-1 | Internal bus target register address |
| sb_wdata | output | 2*REG_W | Internal bus write data |
| sb_ack | input | 1 | Internal bus acknowledge |
| sb_err | input | 1 | Internal bus error, valid with sb_ack |
| sb_rdata | input | 2*REG_W | Internal bus read data, valid with sb_ack |
| sb_rst | output | 1 | Reset toward the internal bus |

## Verification
Every registered result of this bridge appears one clock edge after the stimulus that causes it. Request and busy follow a command write, captured data and sticky flags follow the acknowledge edge, the clear takes effect one edge after its write, and the bus reset starts one edge after its write. reg_rdata is a combinational mux of the holding words. The bench drives every input at a falling edge and samples at the next falling edge, after exactly one rising edge, so each check sits on the cycle where the value is due. The bus reset pulse is measured by counting falling edges while sb_rst is high.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // Word addresses on the register port; software depends on these.
  typedef enum logic [2:0] {
    WA_DATA_HI = 3'h0,
    WA_DATA_LO = 3'h1,
    WA_CMD     = 3'h2,
    WA_CLEAR   = 3'h6,
    WA_BUS_RST = 3'h7
  } word_addr_e;

  // One-hot-or-none write strobes produced by the decoder.
  typedef struct packed {
    logic ld_hi;
    logic ld_lo;
    logic cmd;
    logic clr;
    logic bus_rst;
  } strobe_t;

endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
  import sbr_pkg::*;
(
  input  logic       wr,
  input  logic [2:0] addr,
  input  logic       go_bit,
  output strobe_t    stb
);

  always_comb begin
    stb = '0;
    if (wr) begin
      case (addr)
        WA_DATA_HI: stb.ld_hi   = 1'b1;
        WA_DATA_LO: stb.ld_lo   = 1'b1;
        WA_CMD:     stb.cmd     = 1'b1;
        WA_CLEAR:   stb.clr     = go_bit;
        WA_BUS_RST: stb.bus_rst = go_bit;
        default:    stb         = '0;
      endcase
    end
  end

endmodule

// File: rtl/sbr_xact.sv
module sbr_xact #(
  parameter int REG_W   = 32,
  parameter int TADDR_W = REG_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cmd_stb,
  input  logic [REG_W-1:0]   cmd_word,
  input  logic               ack,
  input  logic               err_in,
  output logic               req,
  output logic               we,
  output logic [TADDR_W-1:0] addr,
  output logic               bus_err,
  output logic               drop_err,
  output logic               launch,
  output logic               drop,
  output logic               done,
  output logic               cap_en
);

  // Named internal events, visible to the checker.
  assign launch = cmd_stb && !req && !clr;
  assign drop   = cmd_stb &&  req && !clr;
  assign done   = req && ack && !clr;
  assign cap_en = done && !we;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      req      <= 1'b0;
      we       <= 1'b0;
      addr     <= '0;
      bus_err  <= 1'b0;
      drop_err <= 1'b0;
    end else begin
      if (launch) begin
        req  <= 1'b1;
        we   <= cmd_word[REG_W-1];
        addr <= cmd_word[TADDR_W-1:0];
      end
      if (done) begin
        req <= 1'b0;
        if (err_in) bus_err <= 1'b1;
      end
      if (drop) drop_err <= 1'b1;
    end
  end

endmodule

// File: rtl/sbr_datareg.sv
module sbr_datareg
  import sbr_pkg::*;
#(
  parameter int REG_W = 32,
  localparam int BUS_W = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             busy,
  input  logic             ld_hi,
  input  logic             ld_lo,
  input  logic [REG_W-1:0] wdata,
  input  logic             cap_en,
  input  logic             cap_err,
  input  logic [BUS_W-1:0] cap_data,
  input  logic [2:0]       rd_addr,
  output logic [REG_W-1:0] hi,
  output logic [REG_W-1:0] lo,
  output logic [REG_W-1:0] rdata
);

  function automatic logic [BUS_W-1:0] result_of(input logic fail,
                                                 input logic [BUS_W-1:0] d);
    return fail ? {BUS_W{1'b1}} : d;
  endfunction

  function automatic logic [REG_W-1:0] upper_of(input logic [BUS_W-1:0] d);
    return d[BUS_W-1:REG_W];
  endfunction

  function automatic logic [REG_W-1:0] lower_of(input logic [BUS_W-1:0] d);
    return d[REG_W-1:0];
  endfunction

  logic [BUS_W-1:0] result;
  assign result = result_of(cap_err, cap_data);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hi <= '0;
      lo <= '0;
    end else if (cap_en) begin
      hi <= upper_of(result);
      lo <= lower_of(result);
    end else if (!busy) begin
      if (ld_hi) hi <= wdata;
      if (ld_lo) lo <= wdata;
    end
  end

  always_comb begin
    case (rd_addr)
      WA_DATA_HI: rdata = hi;
      WA_DATA_LO: rdata = lo;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/sbr_busrst.sv
module sbr_busrst #(
  parameter int CYCLES = 4,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic rst_out
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= CW'(CYCLES);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign rst_out = (remain != '0);

endmodule

// File: rtl/scan_bridge.sv
module scan_bridge
  import sbr_pkg::*;
#(
  parameter int REG_W          = 32,
  parameter int BUS_RST_CYCLES = 4,
  localparam int BUS_W   = 2 * REG_W,
  localparam int TADDR_W = REG_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               busy,
  output logic               bus_err,
  output logic               drop_err,
  output logic               sb_req,
  output logic               sb_we,
  output logic [TADDR_W-1:0] sb_addr,
  output logic [BUS_W-1:0]   sb_wdata,
  input  logic               sb_ack,
  input  logic               sb_err,
  input  logic [BUS_W-1:0]   sb_rdata,
  output logic               sb_rst
);

  strobe_t          stb;
  logic             launch, drop, done, cap_en;
  logic [REG_W-1:0] hi_q, lo_q;

  sbr_decode u_dec (
    .wr     (reg_wr),
    .addr   (reg_addr),
    .go_bit (reg_wdata[REG_W-1]),
    .stb    (stb)
  );

  sbr_xact #(.REG_W(REG_W)) u_xact (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (stb.clr),
    .cmd_stb  (stb.cmd),
    .cmd_word (reg_wdata),
    .ack      (sb_ack),
    .err_in   (sb_err),
    .req      (sb_req),
    .we       (sb_we),
    .addr     (sb_addr),
    .bus_err  (bus_err),
    .drop_err (drop_err),
    .launch   (launch),
    .drop     (drop),
    .done     (done),
    .cap_en   (cap_en)
  );

  assign busy = sb_req;

  sbr_datareg #(.REG_W(REG_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (stb.clr),
    .busy     (busy),
    .ld_hi    (stb.ld_hi),
    .ld_lo    (stb.ld_lo),
    .wdata    (reg_wdata),
    .cap_en   (cap_en),
    .cap_err  (sb_err),
    .cap_data (sb_rdata),
    .rd_addr  (reg_addr),
    .hi       (hi_q),
    .lo       (lo_q),
    .rdata    (reg_rdata)
  );

  // Holding words stay frozen while busy, so they drive the bus directly.
  assign sb_wdata = {hi_q, lo_q};

  sbr_busrst #(.CYCLES(BUS_RST_CYCLES)) u_brst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (stb.bus_rst),
    .rst_out (sb_rst)
  );

endmodule

// File: rtl/scan_bridge_chk.sv
module scan_bridge_chk #(
  parameter int REG_W = 32,
  localparam int BUS_W   = 2 * REG_W,
  localparam int TADDR_W = REG_W - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               bus_rst_stb,
  input logic               launch,
  input logic               drop,
  input logic               done,
  input logic               sb_req,
  input logic               sb_we,
  input logic [TADDR_W-1:0] sb_addr,
  input logic [BUS_W-1:0]   sb_wdata,
  input logic               sb_ack,
  input logic               sb_err,
  input logic               sb_rst,
  input logic               bus_err,
  input logic               drop_err,
  input logic [REG_W-1:0]   hi,
  input logic [REG_W-1:0]   lo
);

  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> sb_req);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req && !sb_ack && !clr |=> sb_req);

  p_cmd_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req && !sb_ack && !clr |=> $stable(sb_we) && $stable(sb_addr) && $stable(sb_wdata));

  p_drop_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> drop_err);

  p_data_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req && !sb_ack && !clr |=> $stable(hi) && $stable(lo));

  p_bus_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && sb_err |=> bus_err);

  p_read_fail_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && sb_err && !sb_we |=> (hi == {REG_W{1'b1}}) && (lo == {REG_W{1'b1}}));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !sb_req && !bus_err && !drop_err && (hi == '0) && (lo == '0));

  p_clear_no_bus_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !sb_rst && !bus_rst_stb |=> !sb_rst);

endmodule

bind scan_bridge scan_bridge_chk #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (stb.clr),
  .bus_rst_stb (stb.bus_rst),
  .launch      (launch),
  .drop        (drop),
  .done        (done),
  .sb_req      (sb_req),
  .sb_we       (sb_we),
  .sb_addr     (sb_addr),
  .sb_wdata    (sb_wdata),
  .sb_ack      (sb_ack),
  .sb_err      (sb_err),
  .sb_rst      (sb_rst),
  .bus_err     (bus_err),
  .drop_err    (drop_err),
  .hi          (hi_q),
  .lo          (lo_q)
);

// File: tb/scan_bridge_tb_top.sv
module scan_bridge_tb_top;

  localparam int RW   = 32;
  localparam int BW   = 64;
  localparam int RCYC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          busy, bus_err, drop_err;
  logic          sb_req, sb_we, sb_rst;
  logic [RW-2:0] sb_addr;
  logic [BW-1:0] sb_wdata;
  logic          sb_ack = 1'b0;
  logic          sb_err = 1'b0;
  logic [BW-1:0] sb_rdata = '0;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  scan_bridge #(.REG_W(RW), .BUS_RST_CYCLES(RCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .bus_err(bus_err), .drop_err(drop_err), .sb_req(sb_req), .sb_we(sb_we),
    .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_ack(sb_ack), .sb_err(sb_err),
    .sb_rdata(sb_rdata), .sb_rst(sb_rst)
  );

  typedef struct packed {
    logic          wr;
    logic [30:0]   addr;
    logic [63:0]   data;
    logic          err;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{wr: 1'b1, addr: 31'h0000_0C09, data: 64'h0123_4567_89AB_CDEF, err: 1'b0},
    '{wr: 1'b0, addr: 31'h0001_0012, data: 64'hFEDC_BA98_7654_3210, err: 1'b0},
    '{wr: 1'b0, addr: 31'h7FFF_FFFF, data: 64'h5555_AAAA_0F0F_F0F0, err: 1'b1},
    '{wr: 1'b1, addr: 31'h0000_0001, data: 64'hFFFF_0000_1234_8000, err: 1'b1},
    '{wr: 1'b0, addr: 31'h0000_0000, data: 64'h0000_0000_0000_0000, err: 1'b0}
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [RW-1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic bus_ack(input logic e, input logic [BW-1:0] d);
    @(negedge clk);
    sb_ack = 1'b1; sb_err = e; sb_rdata = d;
    @(negedge clk);
    sb_ack = 1'b0; sb_err = 1'b0;
  endtask

  task automatic clear_bridge();
    reg_write(3'h6, 32'h8000_0000);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [RW-1:0] v, w;
    int hi_cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 sb_req", sb_req, 0);
    chk("R1 bus_err", bus_err, 0);
    chk("R1 drop_err", drop_err, 0);
    chk("R1 sb_rst", sb_rst, 0);
    reg_read(3'h0, v); chk("R1 upper word", v, 0);
    reg_read(3'h1, v); chk("R1 lower word", v, 0);

    // R2 holding words and unmapped reads
    reg_write(3'h0, 32'hA5A5_0001);
    reg_write(3'h1, 32'h5A5A_0002);
    reg_read(3'h0, v); chk("R2 upper word", v, 32'hA5A5_0001);
    reg_read(3'h1, v); chk("R2 lower word", v, 32'h5A5A_0002);
    reg_read(3'h2, v); chk("R2 word 2 reads zero", v, 0);
    reg_read(3'h5, v); chk("R2 word 5 reads zero", v, 0);
    reg_read(3'h7, v); chk("R2 word 7 reads zero", v, 0);

    // Vector table: R3, R4, R5, R7, R8
    for (int i = 0; i < NV; i++) begin
      logic [63:0] exp_d;
      clear_bridge();
      if (VECS[i].wr) begin
        reg_write(3'h0, VECS[i].data[63:32]);
        reg_write(3'h1, VECS[i].data[31:0]);
      end
      reg_write(3'h2, {VECS[i].wr, VECS[i].addr});
      chk("R3 sb_req", sb_req, 1);
      chk("R3 busy", busy, 1);
      chk("R3 sb_we", sb_we, VECS[i].wr);
      chk("R3 sb_addr", sb_addr, VECS[i].addr);
      if (VECS[i].wr) chk("R3 sb_wdata", sb_wdata, VECS[i].data);
      repeat (2) @(negedge clk);
      chk("R5 req held", sb_req, 1);
      chk("R5 addr held", sb_addr, VECS[i].addr);
      bus_ack(VECS[i].err, VECS[i].wr ? ~VECS[i].data : VECS[i].data);
      chk("R5 req released", sb_req, 0);
      chk("R5 busy released", busy, 0);
      chk("R7 bus_err", bus_err, VECS[i].err);
      if (VECS[i].wr)          exp_d = VECS[i].data;
      else if (VECS[i].err)    exp_d = '1;
      else                     exp_d = VECS[i].data;
      reg_read(3'h0, v);
      reg_read(3'h1, w);
      if (VECS[i].wr)       chk("R7 write leaves data", {v, w}, exp_d);
      else if (VECS[i].err) chk("R8 read error ones", {v, w}, exp_d);
      else                  chk("R4 read capture", {v, w}, exp_d);
    end

    // R6 command and data writes while busy
    clear_bridge();
    reg_write(3'h2, {1'b0, 31'h0000_0123});
    reg_write(3'h2, {1'b1, 31'h0000_0456});
    chk("R6 drop_err set", drop_err, 1);
    chk("R6 addr kept", sb_addr, 31'h0000_0123);
    chk("R6 we kept", sb_we, 0);
    reg_write(3'h0, 32'h1111_2222);
    reg_write(3'h1, 32'h3333_4444);
    reg_read(3'h0, v); chk("R6 upper ignored", v, 0);
    reg_read(3'h1, v); chk("R6 lower ignored", v, 0);
    bus_ack(1'b0, 64'h0BAD_F00D_CAFE_0001);
    chk("R6 drop_err sticky", drop_err, 1);
    reg_read(3'h0, v); chk("R4 capture after drop", v, 32'h0BAD_F00D);

    // R9 clear with bit 31 clear does nothing
    reg_write(3'h6, 32'h7FFF_FFFF);
    chk("R9 no-op clear keeps drop_err", drop_err, 1);
    reg_read(3'h1, v); chk("R9 no-op clear keeps data", v, 32'hCAFE_0001);

    // R9 clear mid-transaction, late ack ignored; R10 no bus reset
    reg_write(3'h2, {1'b0, 31'h0000_0777});
    chk("R9 launched", sb_req, 1);
    clear_bridge();
    chk("R9 req cleared", sb_req, 0);
    chk("R9 busy cleared", busy, 0);
    chk("R9 drop_err cleared", drop_err, 0);
    chk("R10 clear leaves sb_rst low", sb_rst, 0);
    reg_read(3'h1, v); chk("R9 data cleared", v, 0);
    bus_ack(1'b1, 64'h1234_5678_9ABC_DEF0);
    chk("R9 late ack no bus_err", bus_err, 0);
    reg_read(3'h0, v); chk("R9 late ack no capture", v, 0);

    // R10 bus reset pulse
    reg_write(3'h7, 32'h0000_0001);
    chk("R10 bit31 clear no pulse", sb_rst, 0);
    reg_write(3'h7, 32'h8000_0000);
    hi_cnt = 0;
    while (sb_rst && hi_cnt < 50) begin
      hi_cnt++;
      @(negedge clk);
    end
    chk("R10 pulse length", hi_cnt, RCYC);
    chk("R10 busy untouched", busy, 0);

    summary();
    $finish;
  end

endmodule